// File: doc/BRIEF.md
# Periodic Interrupt Timer

This block raises an interrupt flag at a fixed rate that software picks from a set of powers of two. The rate is counted in pulses of a one-cycle tick enable. The tick runs at 32768 Hz, so the slowest setting gives exactly one second. Software controls the timer through four byte-wide registers on a simple write strobe and address bus:

| Offset | Register |
|--------|----------|
| 0 | control: run enable plus period selector |
| 1 | status: always reads zero |
| 2 | interrupt enable |
| 3 | flag register, cleared by writing 1 |

Every write to the control register starts a new full period. When a period ends, the flag is set and the count starts again. The interrupt request is the flag gated by its enable. Read data is registered: it shows the register addressed at the previous clock edge.

Top module: `pit_timer_top`

## Requirements
- R1: The control register (offset 0) and the interrupt-enable register (offset 2) read back all 8 written bits. Read data appears on `rd_data_o` after the rising edge at which `addr_i` selected the register.
- R2: The status register (offset 1) always reads 8'h00, and writes to it change nothing.
- R3: Control bit 0 is the run enable and control bits [6:3] hold the period code n. With the run enable set and n from 1 to 14, the flag first sets on the edge that takes in the 2^(n+1)-th tick after a control write. Code 1 gives 4 ticks and code 14 gives 32768 ticks.
- R4: With code 0, with code 15, or with the run enable clear, the flag never sets, however many ticks arrive.
- R5: After a period ends, counting starts again at once, and the next flag comes after another identical number of ticks.
- R6: A control write discards the count in progress. A tick in the same cycle as a control write is not counted, and a full period follows the write.
- R7: Writing 1 to bit 0 of the flag register (offset 3) clears the flag. Writing 0 to that bit leaves the flag as it is. Flag-register bits [7:1] read 0.
- R8: A period ending in the same cycle as a clear write leaves the flag set. A period ending while the flag is already set leaves it set.
- R9: `irq_o` is 1 exactly when the flag is set and bit 0 of the interrupt-enable register is 1.
- R10: Synchronous active-high reset clears all registers, the count and the read data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle pulse at the 32768 Hz rate |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register offset |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Registered read data |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench sweeps every period code and counts ticks until the request rises. It catches an off-by-one in the period, which would fire one tick early or late, and a wrong code mapping, which would give the wrong power of two. It drives a tick in the same cycle as a control write and a clear in the same cycle as a period end. A design that counted that tick would fire one tick early, and a design that let the clear win would lose an interrupt. It also checks that codes 0 and 15 stay silent, that writing 0 to the flag leaves it set, and that a restart in mid-period gives a full period; a design that got these wrong would fire, lose its flag, or fire early.

// File: rtl/pit_pkg.sv
package pit_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_STAT = 2'd1,
    SEL_IEN  = 2'd2,
    SEL_FLAG = 2'd3
  } reg_sel_e;

  localparam int RUN_BIT  = 0;
  localparam int CODE_LSB = 3;
endpackage

// File: rtl/pit_regs.sv
module pit_regs
  import pit_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              we_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              period_done_i,
  output logic [DATA_W-1:0] ctrl_q_o,
  output logic [DATA_W-1:0] ien_q_o,
  output logic              flag_q_o,
  output logic              ctrl_wr_o,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] ctrl_q, ien_q, rd_q, rd_mux;
  logic              flag_q, flag_clr;

  assign ctrl_wr_o = we_i && (addr_i == SEL_CTRL);
  assign flag_clr  = we_i && (addr_i == SEL_FLAG) && wr_data_i[0];

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      ctrl_q <= '0;
      ien_q  <= '0;
    end else if (we_i) begin
      if (addr_i == SEL_CTRL) ctrl_q <= wr_data_i;
      if (addr_i == SEL_IEN)  ien_q  <= wr_data_i;
    end
  end

  // a period end outranks a clear written in the same cycle
  always_ff @(posedge clk_i) begin
    if (rst_i)              flag_q <= 1'b0;
    else if (period_done_i) flag_q <= 1'b1;
    else if (flag_clr)      flag_q <= 1'b0;
  end

  always_comb begin
    unique case (addr_i)
      SEL_CTRL: rd_mux = ctrl_q;
      SEL_IEN:  rd_mux = ien_q;
      SEL_FLAG: rd_mux = {{(DATA_W-1){1'b0}}, flag_q};
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) rd_q <= '0;
    else       rd_q <= rd_mux;
  end

  assign ctrl_q_o  = ctrl_q;
  assign ien_q_o   = ien_q;
  assign flag_q_o  = flag_q;
  assign rd_data_o = rd_q;
endmodule

// File: rtl/pit_counter.sv
module pit_counter #(
  parameter int CODE_W = 4
) (
  input  logic                        clk_i,
  input  logic                        rst_i,
  input  logic                        tick_i,
  input  logic                        restart_i,
  input  logic                        run_i,
  input  logic [CODE_W-1:0]           code_i,
  output logic                        done_o,
  output logic [(1<<CODE_W)-2:0]      cnt_o
);
  localparam int CODE_MAX = (1 << CODE_W) - 1;
  localparam int CNT_W    = CODE_MAX;

  logic [CNT_W-1:0] cnt_q, last_val;
  logic [CNT_W:0]   period;
  logic             active, at_end;

  assign active   = run_i && (code_i != '0) && (code_i != CODE_W'(CODE_MAX));
  assign period   = (CNT_W+1)'(1) << ({1'b0, code_i} + 1'b1);
  assign last_val = period[CNT_W-1:0] - CNT_W'(1);
  assign at_end   = (cnt_q == last_val);
  assign done_o   = active && tick_i && !restart_i && at_end;

  always_ff @(posedge clk_i) begin
    if (rst_i || restart_i || !active) cnt_q <= '0;
    else if (tick_i)                   cnt_q <= at_end ? '0 : cnt_q + CNT_W'(1);
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/pit_timer_top.sv
module pit_timer_top
  import pit_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CODE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              tick_i,
  input  logic              we_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              irq_o
);
  localparam int CNT_W = (1 << CODE_W) - 1;

  logic [DATA_W-1:0] ctrl_q, ien_q;
  logic              flag_q, ctrl_wr, period_done;
  logic [CNT_W-1:0]  cnt_q;

  pit_regs #(.DATA_W(DATA_W)) regs_i (
    .clk_i(clk_i), .rst_i(rst_i), .we_i(we_i), .addr_i(addr_i),
    .wr_data_i(wr_data_i), .period_done_i(period_done),
    .ctrl_q_o(ctrl_q), .ien_q_o(ien_q), .flag_q_o(flag_q),
    .ctrl_wr_o(ctrl_wr), .rd_data_o(rd_data_o)
  );

  pit_counter #(.CODE_W(CODE_W)) cnt_i (
    .clk_i(clk_i), .rst_i(rst_i), .tick_i(tick_i), .restart_i(ctrl_wr),
    .run_i(ctrl_q[RUN_BIT]), .code_i(ctrl_q[CODE_LSB +: CODE_W]),
    .done_o(period_done), .cnt_o(cnt_q)
  );

  assign irq_o = flag_q & ien_q[0];
endmodule

// File: rtl/pit_checker.sv
module pit_checker #(
  parameter int DATA_W = 8,
  parameter int CODE_W = 4
) (
  input logic                     clk_i,
  input logic                     rst_i,
  input logic                     we_i,
  input logic [1:0]               addr_i,
  input logic [DATA_W-1:0]        wr_data_i,
  input logic [DATA_W-1:0]        rd_data_o,
  input logic                     irq_o,
  input logic [DATA_W-1:0]        ctrl_q,
  input logic [DATA_W-1:0]        ien_q,
  input logic                     flag_q,
  input logic                     period_done,
  input logic [(1<<CODE_W)-2:0]   cnt_q
);
  localparam int CODE_MAX = (1 << CODE_W) - 1;
  logic [CODE_W-1:0] code;
  assign code = ctrl_q[3 +: CODE_W];

  AST_STATUS_READS_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
    ($past(addr_i) == 2'd1 && !$past(rst_i)) |-> rd_data_o == '0); // R2
  AST_FLAG_SET_ON_END: assert property (@(posedge clk_i) disable iff (rst_i)
    period_done |=> flag_q); // R3
  AST_IDLE_NO_END: assert property (@(posedge clk_i) disable iff (rst_i)
    (!ctrl_q[0] || code == '0 || code == CODE_W'(CODE_MAX)) |-> !period_done); // R4
  AST_FLAG_RISE_CAUSE: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(flag_q) |-> $past(period_done)); // R5
  AST_RESTART_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
    (we_i && addr_i == 2'd0) |=> cnt_q == '0); // R6
  AST_FLAG_HOLDS: assert property (@(posedge clk_i) disable iff (rst_i)
    (flag_q && !(we_i && addr_i == 2'd3 && wr_data_i[0])) |=> flag_q); // R8
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk_i) disable iff (rst_i)
    irq_o |-> (ien_q[0] && flag_q)); // R9
endmodule

bind pit_timer_top pit_checker #(.DATA_W(DATA_W), .CODE_W(CODE_W)) chk_i (
  .clk_i(clk_i), .rst_i(rst_i), .we_i(we_i), .addr_i(addr_i),
  .wr_data_i(wr_data_i), .rd_data_o(rd_data_o), .irq_o(irq_o),
  .ctrl_q(ctrl_q), .ien_q(ien_q), .flag_q(flag_q),
  .period_done(period_done), .cnt_q(cnt_q)
);

// File: tb/pit_timer_top_tb_top.sv
module pit_timer_top_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       we = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       irq;
  int         n_chk = 0;
  int         n_bad = 0;
  bit         finished = 1'b0;

  always #2 clk = ~clk;

  pit_timer_top dut_i (
    .clk_i(clk), .rst_i(rst), .tick_i(tick), .we_i(we), .addr_i(addr),
    .wr_data_i(wdata), .rd_data_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1; tick = 1'b0;
    @(posedge clk); #1;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk); addr = a; we = 1'b0; tick = 1'b0;
    @(posedge clk); #1; v = rdata;
  endtask

  task automatic tk(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); we = 1'b0; tick = 1'b1;
      @(posedge clk); #1;
    end
  endtask

  // ticks until irq rises, capped
  task automatic count_to_irq(input int cap, output int k);
    k = 0;
    while (!irq && k < cap) begin tk(1); k++; end
  endtask

  function automatic logic [7:0] ctrl_val(input int code, input bit en);
    return 8'((code << 3) | int'(en));
  endfunction

  initial begin
    logic [7:0] v;
    int k;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R10 reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v); chk("R10 reset read", v, 0);
    end
    chk("R10 reset irq", irq, 0);

    // R1 readback, R2 status
    wr(2'd0, 8'hA2); rd(2'd0, v); chk("R1 ctrl readback", v, 8'hA2);
    wr(2'd2, 8'h5A); rd(2'd2, v); chk("R1 ien readback", v, 8'h5A);
    wr(2'd1, 8'hFF); rd(2'd1, v); chk("R2 status zero", v, 0);
    rd(2'd0, v); chk("R2 status write no effect ctrl", v, 8'hA2);
    rd(2'd2, v); chk("R2 status write no effect ien", v, 8'h5A);

    // R3 every code, R5 rearm on low codes
    wr(2'd2, 8'h01);
    for (int c = 1; c <= 14; c++) begin
      wr(2'd3, 8'h01);
      wr(2'd0, ctrl_val(c, 1'b1));
      count_to_irq(70000, k);
      chk($sformatf("R3 period code %0d", c), k, 1 << (c + 1));
      if (c <= 8) begin
        wr(2'd3, 8'h01);
        chk("R7 clear drops irq", irq, 0);
        count_to_irq(70000, k);
        chk($sformatf("R5 rearm code %0d", c), k, 1 << (c + 1));
      end
    end

    // R7 flag register behaviour (flag set from last period)
    rd(2'd3, v); chk("R7 flag reads 1 upper 0", v, 1);
    wr(2'd3, 8'hFE); rd(2'd3, v); chk("R7 write 0 keeps flag", v, 1);
    wr(2'd3, 8'h01); rd(2'd3, v); chk("R7 write 1 clears flag", v, 0);

    // R4 inactive settings
    wr(2'd0, ctrl_val(0, 1'b1)); tk(300); chk("R4 code 0 silent", irq, 0);
    wr(2'd0, ctrl_val(15, 1'b1)); tk(300); chk("R4 code 15 silent", irq, 0);
    wr(2'd0, ctrl_val(1, 1'b0)); tk(300); chk("R4 enable off silent", irq, 0);
    rd(2'd3, v); chk("R4 flag still clear", v, 0);

    // R6 restart mid-period
    wr(2'd0, ctrl_val(3, 1'b1)); tk(10);
    chk("R6 no early irq", irq, 0);
    wr(2'd0, ctrl_val(3, 1'b1));
    count_to_irq(1000, k); chk("R6 restart full period", k, 16);
    // R6 tick coinciding with the control write is discarded
    wr(2'd3, 8'h01);
    @(negedge clk); addr = 2'd0; wdata = ctrl_val(3, 1'b1); we = 1'b1; tick = 1'b1;
    @(posedge clk); #1;
    count_to_irq(1000, k); chk("R6 coincident tick ignored", k, 16);

    // R8 sticky flag across another period end
    tk(16); chk("R8 flag stays set", irq, 1);
    // R8 set beats clear in the same cycle
    wr(2'd3, 8'h01);
    wr(2'd0, ctrl_val(1, 1'b1)); tk(3);
    chk("R8 not yet", irq, 0);
    @(negedge clk); addr = 2'd3; wdata = 8'h01; we = 1'b1; tick = 1'b1;
    @(posedge clk); #1;
    chk("R8 set wins over clear", irq, 1);

    // R9 gating
    wr(2'd0, ctrl_val(0, 1'b0));
    wr(2'd2, 8'h00); chk("R9 irq masked", irq, 0);
    rd(2'd3, v); chk("R9 flag kept while masked", v, 1);
    wr(2'd2, 8'h01); chk("R9 irq unmasked", irq, 1);

    // R10 reset mid-run
    wr(2'd0, ctrl_val(2, 1'b1));
    @(negedge clk); rst = 1'b1; we = 1'b0; tick = 1'b0;
    @(negedge clk); rst = 1'b0;
    chk("R10 irq after reset", irq, 0);
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v); chk("R10 regs after reset", v, 0);
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule